// File: doc/BRIEF.md
# Bootstrap Charge Sequencer

This block stands between the per-phase switching requests and the gate drive outputs of a half-bridge array. For each phase it checks that the bootstrap capacitor feeding the high-side driver holds enough charge before that driver is allowed on. It keeps checking while the high side conducts. Two synchronized comparator bits per phase give the charge level. One bit says the voltage is above the higher turn-on threshold. The other says it is above the lower turn-off threshold.

When a high-side request arrives with too little charge, the block holds the request back. It runs a charge cycle instead, switching on the low side of the same phase. When the turn-on threshold is crossed, it hands over to the high side through the normal dead-time gap. If the charge does not arrive within a bounded number of cycles, the phase raises a latched bootstrap fault. Every gate of every phase is then forced off until a supervisor clear pulse arrives. A per-gate dead-time stage makes sure no gate turns on until its complement has been off long enough.

Top module: `bootcharge_seq`

## Requirements
- R1: After reset, all gate outputs and all fault flags are 0. Each phase starts in the request-following state, and the dead-time gaps count as already elapsed.
- R2: While following requests, a low request (req_lo=1) drives the low gate. A high request made together with a low request drives the low gate only. Neither gate is on without a request.
- R3: A high-only request (req_hi=1, req_lo=0) with lvl_on_ok=1 turns the high gate on. The low gate stays off.
- R4: A high-only request with lvl_on_ok=0 does not turn the high gate on. It starts a charge cycle that drives the low gate of that phase instead.
- R5: When lvl_on_ok rises during a charge cycle, the low gate turns off. The high gate then turns on after the dead-time gap.
- R6: While the high gate is on, lvl_off_ok=0 starts a new charge cycle: the high gate goes off and the low gate comes on after the gap. Only lvl_off_ok is watched in this state, so lvl_on_ok=0 alone has no effect.
- R7: A charge cycle that lasts TIMEOUT_CYCLES clock cycles without lvl_on_ok sets bst_fault for that phase. If lvl_on_ok arrives in the final cycle, that charge succeeds and no fault is raised. The timeout restarts at the start of every charge cycle.
- R8: While any bst_fault bit is 1, every gate output of every phase is 0 from the next clock onward. A fault stays set, whatever the inputs are, until clr_fault.
- R9: If the high request is withdrawn during a charge cycle, or a low request joins it, the phase goes back to following requests without a fault. This holds even in the final timeout cycle.
- R10: A gate turns on only after its complement has been off for DEAD_CYCLES consecutive clock edges. The high and low gates of a phase are never on together.
- R11: A clr_fault pulse returns every faulted phase to request following with bst_fault=0. clr_fault has no effect on a phase that is not faulted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_hi | input | NPH | High-side request per phase |
| req_lo | input | NPH | Low-side request per phase |
| lvl_on_ok | input | NPH | Bootstrap voltage above turn-on level (synchronized) |
| lvl_off_ok | input | NPH | Bootstrap voltage above turn-off level (synchronized) |
| clr_fault | input | 1 | Supervisor fault clear pulse |
| gate_hi | output | NPH | High-side gate command per phase |
| gate_lo | output | NPH | Low-side gate command per phase |
| bst_fault | output | NPH | Latched bootstrap charge fault per phase |

## Verification
Charge success and timeout expiry can land in the same clock: the last cycle of a charge cycle may also be the one in which the turn-on level is reached. The bench provokes this by raising lvl_on_ok exactly TIMEOUT_CYCLES edges after the charge cycle begins, and expects a clean hand-over to the high gate with no fault. A second directed case withdraws the request in that same final cycle and expects a fault-free return to request following. Every cycle is also compared against a bench model under random request and level patterns.

// File: rtl/bcs_pkg.sv
package bcs_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_CHARGE = 2'd1,
    ST_HIGH   = 2'd2,
    ST_FAULT  = 2'd3
  } bcs_state_e;

  typedef struct packed {
    logic hi;
    logic lo;
  } gate_cmd_t;

endpackage

// File: rtl/bcs_charge_timer.sv
module bcs_charge_timer #(
  parameter int TIMEOUT_CYCLES = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic advance,
  output logic expired
);
  localparam int CW = (TIMEOUT_CYCLES > 1) ? $clog2(TIMEOUT_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(TIMEOUT_CYCLES - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  assign expired = (cnt_q == LAST);

  always_comb begin
    cnt_d = cnt_q;
    if (restart) begin
      cnt_d = '0;
    end else if (advance && !expired) begin
      cnt_d = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  // R7: each charge cycle begins from a fresh count
  p_restart_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt_q == '0));

  // R7: the count climbs by one per charge cycle clock until the limit
  p_count_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!restart && advance && !expired) |=> (cnt_q == $past(cnt_q) + CW'(1)));

endmodule

// File: rtl/bcs_phase_fsm.sv
module bcs_phase_fsm
  import bcs_pkg::*;
#(
  parameter int TIMEOUT_CYCLES = 40
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      req_hi,
  input  logic      req_lo,
  input  logic      lvl_on_ok,
  input  logic      lvl_off_ok,
  input  logic      kill,
  input  logic      clr_fault,
  output gate_cmd_t cmd,
  output logic      fault
);
  bcs_state_e state_q, state_d;
  logic       want_hi;
  logic       tmr_restart;
  logic       tmr_advance;
  logic       tmr_expired;

  assign want_hi = req_hi & ~req_lo;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: begin
        if (!kill && want_hi) begin
          state_d = lvl_on_ok ? ST_HIGH : ST_CHARGE;
        end
      end
      ST_CHARGE: begin
        if (kill || !want_hi) begin
          state_d = ST_IDLE;
        end else if (lvl_on_ok) begin
          state_d = ST_HIGH;
        end else if (tmr_expired) begin
          state_d = ST_FAULT;
        end
      end
      ST_HIGH: begin
        if (kill || !want_hi) begin
          state_d = ST_IDLE;
        end else if (!lvl_off_ok) begin
          state_d = ST_CHARGE;
        end
      end
      ST_FAULT: begin
        if (clr_fault) begin
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  assign tmr_restart = (state_d == ST_CHARGE) && (state_q != ST_CHARGE);
  assign tmr_advance = (state_q == ST_CHARGE);

  bcs_charge_timer #(
    .TIMEOUT_CYCLES(TIMEOUT_CYCLES)
  ) i_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .restart(tmr_restart),
    .advance(tmr_advance),
    .expired(tmr_expired)
  );

  always_comb begin
    cmd.hi = (state_q == ST_HIGH);
    cmd.lo = (state_q == ST_CHARGE) || ((state_q == ST_IDLE) && req_lo);
  end

  assign fault = (state_q == ST_FAULT);

  // R4: an uncharged high request is diverted into a charge cycle
  p_divert_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && want_hi && !lvl_on_ok && !kill) |=> (state_q == ST_CHARGE));

  // R6: charge loss during conduction restarts charging
  p_recharge_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_HIGH && want_hi && !kill && !lvl_off_ok) |=> (state_q == ST_CHARGE));

  // R7: an expired charge cycle without success ends in the fault state
  p_timeout_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_CHARGE && tmr_expired && want_hi && !kill && !lvl_on_ok) |=> fault);

  // R8: a fault is held until the clear pulse
  p_fault_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fault && !clr_fault) |=> fault);

  // R9: withdrawing the request during charging never faults
  p_withdraw_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_CHARGE && !want_hi) |=> !fault);

endmodule

// File: rtl/bcs_gate_stage.sv
module bcs_gate_stage
  import bcs_pkg::*;
#(
  parameter int DEAD_CYCLES = 4
) (
  input  logic      clk,
  input  logic      rst_n,
  input  gate_cmd_t cmd,
  input  logic      kill,
  output logic      gate_hi,
  output logic      gate_lo
);
  localparam int GW = $clog2(DEAD_CYCLES + 1);
  localparam logic [GW-1:0] GAP_DONE = GW'(DEAD_CYCLES);

  logic          gh_q, gl_q, gh_d, gl_d;
  logic [GW-1:0] hi_gap_q, lo_gap_q, hi_gap_d, lo_gap_d;
  logic          hi_ready, lo_ready;

  assign hi_ready = (hi_gap_q == GAP_DONE);
  assign lo_ready = (lo_gap_q == GAP_DONE);

  always_comb begin
    gh_d = cmd.hi & ~kill & ~gl_q & lo_ready;
    gl_d = cmd.lo & ~kill & ~gh_q & hi_ready;

    if (gh_q) begin
      hi_gap_d = '0;
    end else if (!hi_ready) begin
      hi_gap_d = hi_gap_q + GW'(1);
    end else begin
      hi_gap_d = hi_gap_q;
    end

    if (gl_q) begin
      lo_gap_d = '0;
    end else if (!lo_ready) begin
      lo_gap_d = lo_gap_q + GW'(1);
    end else begin
      lo_gap_d = lo_gap_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gh_q     <= 1'b0;
      gl_q     <= 1'b0;
      hi_gap_q <= GAP_DONE;
      lo_gap_q <= GAP_DONE;
    end else begin
      gh_q     <= gh_d;
      gl_q     <= gl_d;
      hi_gap_q <= hi_gap_d;
      lo_gap_q <= lo_gap_d;
    end
  end

  assign gate_hi = gh_q;
  assign gate_lo = gl_q;

  // R10: the two gates of a phase never conduct together
  p_exclusive_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate_hi && gate_lo));

  // R10: a gate only rises after its complement was already low
  p_hi_after_lo_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_hi) |-> $past(!gate_lo));

  p_lo_after_hi_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_lo) |-> $past(!gate_hi));

  // R8: the global kill clears both gates on the next edge
  p_kill_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    kill |=> (!gate_hi && !gate_lo));

endmodule

// File: rtl/bootcharge_seq.sv
module bootcharge_seq
  import bcs_pkg::*;
#(
  parameter int NPH            = 2,
  parameter int TIMEOUT_CYCLES = 40,
  parameter int DEAD_CYCLES    = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NPH-1:0] req_hi,
  input  logic [NPH-1:0] req_lo,
  input  logic [NPH-1:0] lvl_on_ok,
  input  logic [NPH-1:0] lvl_off_ok,
  input  logic           clr_fault,
  output logic [NPH-1:0] gate_hi,
  output logic [NPH-1:0] gate_lo,
  output logic [NPH-1:0] bst_fault
);
  gate_cmd_t      cmd [NPH];
  logic [NPH-1:0] fault_vec;
  logic           kill;

  assign kill      = |fault_vec;
  assign bst_fault = fault_vec;

  for (genvar p = 0; p < NPH; p++) begin : g_phase
    bcs_phase_fsm #(
      .TIMEOUT_CYCLES(TIMEOUT_CYCLES)
    ) i_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_hi    (req_hi[p]),
      .req_lo    (req_lo[p]),
      .lvl_on_ok (lvl_on_ok[p]),
      .lvl_off_ok(lvl_off_ok[p]),
      .kill      (kill),
      .clr_fault (clr_fault),
      .cmd       (cmd[p]),
      .fault     (fault_vec[p])
    );

    bcs_gate_stage #(
      .DEAD_CYCLES(DEAD_CYCLES)
    ) i_gate (
      .clk    (clk),
      .rst_n  (rst_n),
      .cmd    (cmd[p]),
      .kill   (kill),
      .gate_hi(gate_hi[p]),
      .gate_lo(gate_lo[p])
    );
  end

  // R8: any fault leaves the whole array dark on the following edge
  p_array_dark_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (|bst_fault) |=> (gate_hi == '0 && gate_lo == '0));

  // R11: the clear pulse removes every latched fault
  p_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    clr_fault |=> (bst_fault == '0));

endmodule

// File: tb/test_bootcharge_seq.sv
`timescale 1ns/1ps
module test_bootcharge_seq;
  localparam int NPH = 2;
  localparam int TO  = 40;
  localparam int DT  = 4;

  logic           clk;
  logic           rst_n;
  logic [NPH-1:0] req_hi, req_lo, lvl_on_ok, lvl_off_ok;
  logic           clr_fault;
  logic [NPH-1:0] gate_hi, gate_lo, bst_fault;

  int    n_vec;
  int    n_bad;
  bit    done;
  bit    chk_en;
  string tag;

  // bench model state: 0 follow, 1 charging, 2 high on, 3 faulted
  int m_st [NPH];
  int m_cnt[NPH];
  int m_gh [NPH];
  int m_gl [NPH];
  int m_hrun[NPH];
  int m_lrun[NPH];

  bootcharge_seq #(.NPH(NPH), .TIMEOUT_CYCLES(TO), .DEAD_CYCLES(DT)) i_bootcharge_seq (
    .clk(clk), .rst_n(rst_n), .req_hi(req_hi), .req_lo(req_lo),
    .lvl_on_ok(lvl_on_ok), .lvl_off_ok(lvl_off_ok), .clr_fault(clr_fault),
    .gate_hi(gate_hi), .gate_lo(gate_lo), .bst_fault(bst_fault)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic int sat_inc(int v);
    return (v >= DT) ? DT : v + 1;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int p = 0; p < NPH; p++) begin
        m_st[p] = 0; m_cnt[p] = 0; m_gh[p] = 0; m_gl[p] = 0;
        m_hrun[p] = DT; m_lrun[p] = DT;
      end
    end else begin
      bit any_f;
      int nst[NPH];
      int ncnt[NPH];
      any_f = 0;
      for (int p = 0; p < NPH; p++) if (m_st[p] == 3) any_f = 1;
      for (int p = 0; p < NPH; p++) begin
        bit wh, ch, cl;
        wh = req_hi[p] && !req_lo[p];
        nst[p] = m_st[p];
        ncnt[p] = m_cnt[p];
        ch = (m_st[p] == 2);
        cl = (m_st[p] == 1) || (m_st[p] == 0 && req_lo[p]);
        if (m_st[p] == 0) begin
          if (!any_f && wh) begin
            if (lvl_on_ok[p]) nst[p] = 2;
            else begin nst[p] = 1; ncnt[p] = 0; end
          end
        end else if (m_st[p] == 1) begin
          if (any_f || !wh) nst[p] = 0;
          else if (lvl_on_ok[p]) nst[p] = 2;
          else if (m_cnt[p] == TO - 1) nst[p] = 3;
          else ncnt[p] = m_cnt[p] + 1;
        end else if (m_st[p] == 2) begin
          if (any_f || !wh) nst[p] = 0;
          else if (!lvl_off_ok[p]) begin nst[p] = 1; ncnt[p] = 0; end
        end else begin
          if (clr_fault) nst[p] = 0;
        end
        begin
          int ngh, ngl;
          ngh = (ch && !any_f && m_gl[p] == 0 && m_lrun[p] >= DT) ? 1 : 0;
          ngl = (cl && !any_f && m_gh[p] == 0 && m_hrun[p] >= DT) ? 1 : 0;
          m_hrun[p] = m_gh[p] ? 0 : sat_inc(m_hrun[p]);
          m_lrun[p] = m_gl[p] ? 0 : sat_inc(m_lrun[p]);
          m_gh[p] = ngh;
          m_gl[p] = ngl;
        end
      end
      for (int p = 0; p < NPH; p++) begin
        m_st[p] = nst[p];
        m_cnt[p] = ncnt[p];
      end
    end
  end

  task automatic check_bit(string t, string what, int act, int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", t, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (chk_en) begin
      for (int p = 0; p < NPH; p++) begin
        check_bit(tag, $sformatf("gate_hi[%0d]", p), int'(gate_hi[p]), m_gh[p]);
        check_bit(tag, $sformatf("gate_lo[%0d]", p), int'(gate_lo[p]), m_gl[p]);
        check_bit(tag, $sformatf("bst_fault[%0d]", p), int'(bst_fault[p]), (m_st[p] == 3) ? 1 : 0);
      end
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_lvl(int p, int v);
    lvl_off_ok[p] = (v >= 1);
    lvl_on_ok[p]  = (v == 2);
  endtask

  task automatic quiet();
    req_hi = '0; req_lo = '0; clr_fault = 1'b0;
  endtask

  initial begin
    n_vec = 0; n_bad = 0; done = 0; chk_en = 0; tag = "R1";
    void'($urandom(32'd4957));
    rst_n = 1'b0;
    quiet();
    lvl_on_ok = '1; lvl_off_ok = '1;
    cyc(3);
    // R1: reset state at the ports
    check_bit("R1", "gate_hi", int'(gate_hi), 0);
    check_bit("R1", "gate_lo", int'(gate_lo), 0);
    check_bit("R1", "bst_fault", int'(bst_fault), 0);
    rst_n = 1'b1;
    chk_en = 1;
    cyc(2);

    // R2: low request followed; both requested gives low only
    tag = "R2";
    req_lo[0] = 1'b1; cyc(3);
    check_bit("R2", "gate_lo[0]", int'(gate_lo[0]), 1);
    req_hi[0] = 1'b1; cyc(4);
    check_bit("R2", "gate_hi[0]", int'(gate_hi[0]), 0);
    quiet(); cyc(DT + 3);

    // R3: charged high request
    tag = "R3";
    set_lvl(0, 2); req_hi[0] = 1'b1; cyc(3);
    check_bit("R3", "gate_hi[0]", int'(gate_hi[0]), 1);
    check_bit("R3", "gate_lo[0]", int'(gate_lo[0]), 0);

    // R6: turn-on level loss alone ignored, turn-off level loss recharges
    tag = "R6";
    set_lvl(0, 1); cyc(4);
    check_bit("R6", "gate_hi[0] on-level only", int'(gate_hi[0]), 1);
    set_lvl(0, 0); cyc(DT + 4);
    check_bit("R6", "gate_hi[0]", int'(gate_hi[0]), 0);
    check_bit("R6", "gate_lo[0]", int'(gate_lo[0]), 1);

    // R5: charge complete hands over through the gap
    tag = "R5";
    set_lvl(0, 2); cyc(DT + 4);
    check_bit("R5", "gate_hi[0]", int'(gate_hi[0]), 1);
    check_bit("R5", "gate_lo[0]", int'(gate_lo[0]), 0);
    quiet(); cyc(DT + 3);

    // R4: uncharged request becomes a low-side charge
    tag = "R4";
    set_lvl(0, 0); req_hi[0] = 1'b1; cyc(DT + 3);
    check_bit("R4", "gate_hi[0]", int'(gate_hi[0]), 0);
    check_bit("R4", "gate_lo[0]", int'(gate_lo[0]), 1);
    quiet(); cyc(DT + 3);

    // R7: success in the final charge cycle wins over the timeout
    tag = "R7";
    set_lvl(0, 0); req_hi[0] = 1'b1; cyc(TO);
    set_lvl(0, 2); cyc(3);
    check_bit("R7", "bst_fault[0] final-cycle success", int'(bst_fault[0]), 0);
    quiet(); cyc(DT + 3);

    // R9: withdrawal in the final charge cycle, no fault
    tag = "R9";
    set_lvl(0, 0); req_hi[0] = 1'b1; cyc(TO);
    req_hi[0] = 1'b0; cyc(3);
    check_bit("R9", "bst_fault[0]", int'(bst_fault[0]), 0);
    quiet(); cyc(DT + 3);

    // R7 / R8: timeout faults, whole array dark and latched
    tag = "R8";
    set_lvl(0, 0); req_hi[0] = 1'b1; cyc(TO + 2);
    check_bit("R7", "bst_fault[0] after timeout", int'(bst_fault[0]), 1);
    req_lo[1] = 1'b1; set_lvl(0, 2); req_hi[0] = 1'b0; cyc(6);
    check_bit("R8", "gate_lo[1] while faulted", int'(gate_lo[1]), 0);
    check_bit("R8", "bst_fault[0] latched", int'(bst_fault[0]), 1);

    // R11: clear pulse
    tag = "R11";
    clr_fault = 1'b1; cyc(1); clr_fault = 1'b0; cyc(DT + 3);
    check_bit("R11", "bst_fault[0]", int'(bst_fault[0]), 0);
    check_bit("R11", "gate_lo[1]", int'(gate_lo[1]), 1);
    quiet(); cyc(DT + 3);

    // R10: random patterns against the model, dead time and exclusion
    tag = "R10";
    for (int i = 0; i < 4000; i++) begin
      for (int p = 0; p < NPH; p++) begin
        int r;
        r = int'($urandom % 10);
        set_lvl(p, (r < 6) ? 2 : ((r < 8) ? 1 : 0));
        if (($urandom % 8) == 0) req_hi[p] = $urandom;
        if (($urandom % 12) == 0) req_lo[p] = $urandom;
      end
      clr_fault = (($urandom % 64) == 0);
      cyc(1);
      for (int p = 0; p < NPH; p++) begin
        n_vec++;
        if (gate_hi[p] && gate_lo[p]) begin
          n_bad++;
          $display("FAIL R10 overlap phase %0d actual=11 expected=not both", p);
        end
      end
    end
    quiet(); cyc(4);
    chk_en = 0;
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule